// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block runs the link test for one 10 Mb/s twisted-pair port. On the transmit side it requests a link test pulse from the line driver whenever the transmitter has been quiet long enough. It keeps doing so at a steady spacing for as long as the quiet lasts. Pulses go out whether the link is up, down or the port is cut off by other logic.

On the receive side it watches two one-cycle strobes: one for a received link test pulse and one for a received data packet. If neither arrives for a long time, the port drops to link fail and the port-enable flag to the repeater core goes low. The link comes back on one data packet. It also comes back on a run of back-to-back link pulses, each arriving within an accepted spacing window.

All timers count a free-running millisecond tick produced by dividing the clock by a parameter. A simulation can therefore shrink every interval.

Top module: `tp_link_monitor`

## Requirements
- R1: After reset `link_pass` and `port_en` are 1 and `lp_req` is 0.
- R2: A tick occurs once every TICK_DIV clocks, counted from reset. When `tx_active` is low, the first pulse on `lp_req` starts on the TX_GAP_MS-th tick seen with `tx_active` low. After each pulse ends, the next one starts on the TX_GAP_MS-th following tick.
- R3: Each pulse on `lp_req` stays high for exactly PULSE_CYC clocks.
- R4: No pulse starts while `tx_active` is high. A pulse already under way is cut off one clock after `tx_active` is seen high.
- R5: Link pulses keep being generated while the link is in fail.
- R6: When FAIL_MS ticks pass with neither `rx_pulse` nor `rx_packet`, `link_pass` drops to 0 on the FAIL_MS-th tick. Any strobe restarts this count.
- R7: In link fail, an `rx_packet` strobe sets `link_pass` to 1 on the next clock.
- R8: In link fail, LP_NEED `rx_pulse` strobes in a row set `link_pass` to 1 one clock after the last of them. This holds only when each spacing from the previous strobe covers between LP_MIN_MS and LP_MAX_MS ticks, inclusive. The ticks counted are those after the previous strobe's clock, up to and including the clock of the current strobe.
- R9: A strobe whose spacing falls outside the window does not extend the run. It starts a new run as its first pulse.
- R10: `port_en` is 0 whenever `link_pass` is 0, and 1 whenever it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_active | input | 1 | Port transmitter is sending data |
| rx_pulse | input | 1 | One-cycle strobe: link test pulse received |
| rx_packet | input | 1 | One-cycle strobe: data packet received |
| lp_req | output | 1 | Link test pulse request to the line driver |
| link_pass | output | 1 | Link integrity state, 1 = pass |
| port_en | output | 1 | Repeater may transmit to this port |

## Verification
The hardest state to reach is link fail with a partly built run of received pulses. A single ill-spaced strobe must then discard the run without reaching pass. The bench first drives the port into fail by holding the receive side silent past the fail limit. It then sends strobes spaced at exact multiples of the tick period, so each spacing covers a known number of ticks. It sweeps that spacing from one tick to two ticks beyond the window. It also breaks valid runs with one short gap and with one long gap, and checks that pass arrives only on the fourth pulse of the new run.

// File: rtl/tp_link_monitor.sv
module tp_link_monitor #(
  parameter int TICK_DIV  = 20000,
  parameter int TX_GAP_MS = 16,
  parameter int PULSE_CYC = 2,
  parameter int FAIL_MS   = 100,
  parameter int LP_MIN_MS = 5,
  parameter int LP_MAX_MS = 30,
  parameter int LP_NEED   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic rx_pulse,
  input  logic rx_packet,
  output logic lp_req,
  output logic link_pass,
  output logic port_en
);
  localparam int DW = $clog2(TICK_DIV);
  localparam int IW = $clog2(TX_GAP_MS + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam int SW = $clog2(FAIL_MS + 1);
  localparam int GW = $clog2(LP_MAX_MS + 2);
  localparam int CW = $clog2(LP_NEED + 1);

  logic [DW-1:0] div_q;
  logic          tick;

  assign tick = (div_q == DW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;

  // transmit side: idle timer and pulse stretcher
  logic [IW-1:0] idle_q;
  logic [PW-1:0] lp_q;
  logic          fire;

  assign fire   = tick && !tx_active && (lp_q == '0) && (idle_q == IW'(TX_GAP_MS - 1));
  assign lp_req = (lp_q != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idle_q <= '0;
      lp_q   <= '0;
    end else if (tx_active) begin
      idle_q <= '0;
      lp_q   <= '0;
    end else if (fire) begin
      idle_q <= '0;
      lp_q   <= PW'(PULSE_CYC);
    end else if (lp_q != '0) begin
      idle_q <= '0;
      lp_q   <= lp_q - 1'b1;
    end else if (tick) begin
      idle_q <= idle_q + 1'b1;
    end

  // receive side: silence timer, pulse spacing, run counter
  logic [SW-1:0] sil_q;
  logic [GW-1:0] gap_q, gap_now;
  logic [CW-1:0] run_q;
  logic          pass_q, gap_ok, silent_end, rx_any;

  assign rx_any     = rx_pulse || rx_packet;
  assign gap_now    = (tick && gap_q != GW'(LP_MAX_MS + 1)) ? gap_q + 1'b1 : gap_q;
  assign gap_ok     = (gap_now >= GW'(LP_MIN_MS)) && (gap_now <= GW'(LP_MAX_MS));
  assign silent_end = tick && !rx_any && (sil_q == SW'(FAIL_MS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sil_q <= '0;
      gap_q <= GW'(LP_MAX_MS + 1);
    end else begin
      if (rx_any)                               sil_q <= '0;
      else if (tick && sil_q != SW'(FAIL_MS))   sil_q <= sil_q + 1'b1;
      gap_q <= rx_pulse ? '0 : gap_now;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pass_q <= 1'b1;
      run_q  <= '0;
    end else if (pass_q) begin
      run_q <= '0;
      if (silent_end) pass_q <= 1'b0;
    end else if (rx_packet) begin
      pass_q <= 1'b1;
      run_q  <= '0;
    end else if (rx_pulse) begin
      if (run_q != '0 && gap_ok) begin
        if (run_q == CW'(LP_NEED - 1)) begin
          pass_q <= 1'b1;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= CW'(1);
      end
    end

  assign link_pass = pass_q;
  assign port_en   = pass_q;
endmodule

// File: rtl/tp_link_monitor_chk.sv
module tp_link_monitor_chk #(
  parameter int PULSE_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic tx_active,
  input logic rx_pulse,
  input logic rx_packet,
  input logic lp_req,
  input logic link_pass,
  input logic port_en
);
  logic [7:0] hi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   hi_q <= '0;
    else if (!lp_req)             hi_q <= '0;
    else if (hi_q != 8'hff)       hi_q <= hi_q + 1'b1;

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |-> (int'(hi_q) < PULSE_CYC)); // R3
  AST_TX_BLOCKS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> !lp_req); // R4
  AST_FAIL_NEEDS_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_pass) |-> !$past(rx_pulse) && !$past(rx_packet)); // R6
  AST_PKT_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_packet |=> link_pass); // R7
  AST_PASS_NEEDS_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_pass) |-> $past(rx_pulse) || $past(rx_packet)); // R8
  AST_PORT_OFF_IN_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    !link_pass |-> !port_en); // R10
endmodule

bind tp_link_monitor tp_link_monitor_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_pulse(rx_pulse),
  .rx_packet(rx_packet), .lp_req(lp_req), .link_pass(link_pass), .port_en(port_en)
);

// File: tb/tp_link_monitor_test.sv
module tp_link_monitor_test;
  localparam int D = 4, G = 5, P = 2, F = 20, LMIN = 3, LMAX = 8, NEED = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_active = 1'b0, rx_pulse = 1'b0, rx_packet = 1'b0;
  logic lp_req, link_pass, port_en;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tp_link_monitor #(.TICK_DIV(D), .TX_GAP_MS(G), .PULSE_CYC(P), .FAIL_MS(F),
                    .LP_MIN_MS(LMIN), .LP_MAX_MS(LMAX), .LP_NEED(NEED)) uut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_pulse(rx_pulse),
    .rx_packet(rx_packet), .lp_req(lp_req), .link_pass(link_pass), .port_en(port_en));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int spacing);
    idle(spacing - 1);
    rx_pulse = 1'b1;
    @(negedge clk);
    rx_pulse = 1'b0;
  endtask

  task automatic go_fail();
    idle((F + 2) * D);
    chk("R6 fail after silence", link_pass, 0);
    chk("R10 port off in fail", port_en, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, w, bad, rises;
    logic prev;
    idle(3);
    chk("R1 link_pass", link_pass, 1);
    chk("R1 port_en", port_en, 1);
    chk("R1 lp_req", lp_req, 0);
    rst_n = 1'b1;

    // R4: no pulses while transmitting
    tx_active = 1'b1;
    bad = 0;
    for (int i = 0; i < 3 * G * D; i++) begin @(negedge clk); if (lp_req) bad++; end
    chk("R4 no pulse during tx", bad, 0);

    // R2 first pulse timing, R3 width, R2 spacing
    tx_active = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!lp_req && n < 4 * G * D);
    chk("R2 first pulse in window", int'(n > (G - 1) * D && n <= G * D), 1);
    w = 1;
    forever begin @(negedge clk); if (lp_req) w++; else break; end
    chk("R3 pulse width", w, P);
    n = w;
    do begin @(negedge clk); n++; end while (!lp_req && n < 4 * G * D);
    chk("R2 pulse spacing", int'(n > P + (G - 1) * D && n <= P + G * D), 1);
    tx_active = 1'b1;
    @(negedge clk);
    chk("R4 tx cuts pulse", lp_req, 0);
    tx_active = 1'b0;

    // R6 exact fail window after last strobe
    rx_packet = 1'b1; @(negedge clk); rx_packet = 1'b0;
    idle((F - 1) * D);
    chk("R6 still pass before limit", link_pass, 1);
    idle(D);
    chk("R6 fail at limit", link_pass, 0);

    // R5 pulses continue in fail
    rises = 0; bad = 0; prev = lp_req;
    for (int i = 0; i < 3 * G * D; i++) begin
      @(negedge clk);
      if (lp_req && !prev) rises++;
      if (link_pass) bad++;
      prev = lp_req;
    end
    chk("R5 pulses in fail", int'(rises >= 2), 1);
    chk("R5 link stays failed", bad, 0);

    // R7 packet restores
    rx_packet = 1'b1; @(negedge clk); rx_packet = 1'b0;
    chk("R7 packet restores", link_pass, 1);
    chk("R10 port on in pass", port_en, 1);

    // R6 regular pulses hold the link
    bad = 0;
    for (int i = 0; i < 10; i++) begin pulse(6 * D); if (!link_pass) bad++; end
    chk("R6 pulses hold link", bad, 0);

    // R8/R9 spacing sweep
    for (int g = 1; g <= LMAX + 2; g++) begin
      go_fail();
      pulse(1);
      for (int k = 1; k < NEED - 1; k++) pulse(g * D);
      chk($sformatf("R8 no pass before last pulse g=%0d", g), link_pass, 0);
      pulse(g * D);
      chk($sformatf("R8 run of four g=%0d", g), link_pass, int'(g >= LMIN && g <= LMAX));
    end

    // R9 short gap breaks run
    go_fail();
    pulse(1); pulse(4 * D); pulse(1 * D); pulse(4 * D); pulse(4 * D);
    chk("R9 short gap restarts run", link_pass, 0);
    pulse(4 * D);
    chk("R9 new run completes", link_pass, 1);

    // R9 long gap breaks run
    go_fail();
    pulse(1); pulse(4 * D); pulse((LMAX + 1) * D); pulse(4 * D); pulse(4 * D);
    chk("R9 long gap restarts run", link_pass, 0);
    pulse(4 * D);
    chk("R9 new run after long gap", link_pass, 1);

    // R7 packet mid-run
    go_fail();
    pulse(1); pulse(4 * D);
    rx_packet = 1'b1; @(negedge clk); rx_packet = 1'b0;
    chk("R7 packet mid-run", link_pass, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule